// File: doc/BRIEF.md
# Single-Access SDRAM Command Sequencer

This block sits between a simple request port and a dual-bank synchronous DRAM of 2048 rows by 256 columns of 16-bit words per bank. It takes one request at a time. Each request carries a flat 20-bit word address, a write flag and a data word. The block turns the request into a fixed command train on the DRAM pins: open the row, perform a single-word column access, and close every bank again. Counted idle gaps separate these commands. On a read, the block takes the word from the data bus after the CAS latency and returns it with a one-cycle strobe.

The burst length is one word. Open rows are never kept between requests. After each access the block waits out the precharge recovery and only then offers its request port again. It accepts nothing until an external signal reports that device initialisation has finished. Command pins use the usual active-low encoding {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010.

Top module: `sdram_seq`

## Requirements
- R1: The flat address splits as bank = addr[19], row = addr[18:8], column = addr[7:0].
- R2: The cycle after a request is accepted carries ACTIVE, with the bank on pin A11 and the row on A10..A0.
- R3: READ or WRITE comes exactly T_RCD cycles after ACTIVE, with the bank on A11, the column on A7..A0 and A10..A8 at zero.
- R4: PRECHARGE comes in the cycle right after READ or WRITE, with A10 at 1 and every other address pin at 0.
- R5: Every other cycle carries NOP with all address pins at zero.
- R6: The data output enable is high only in the WRITE cycle, and the data output then equals the request's write data. When the enable is low, the data output is zero.
- R7: The block samples the data bus at the CAS_LAT-th rising edge after the edge that registers READ. It presents the word on rd_data with rd_valid high for exactly the following cycle.
- R8: req_ready is low from the accepting edge through the T_RP cycles that follow PRECHARGE. It is high again in the next cycle.
- R9: While init_done is low, req_ready stays low, no request is taken and only NOP is issued.
- R10: During reset, the outputs show NOP, a zero address, the output enable low, rd_valid low and req_ready low.
- R11: A read return that falls in the cycle a new request is accepted is delivered intact, and the new request's ACTIVE follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done | input | 1 | Device initialisation finished |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request port free |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Flat word address |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read word valid, one-cycle pulse |
| rd_data | output | 16 | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address pins A11..A0 |
| sd_dq_out | output | 16 | Data bus, drive side |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | 16 | Data bus, receive side |

## Verification
With the default latencies, a read's return strobe lands in the first cycle after recovery. In that same cycle the request port is free again, so data delivery and acceptance of the next request coincide. The bench provokes this by holding the next request valid straight after each acceptance while a chain of reads runs back to back. Its cycle model checks the returned word against a scoreboard in that cycle and checks that ACTIVE for the new request appears one cycle later. A behavioural DRAM model tracks the open row per bank, so any wrong bank or column mapping shows up as a wrong word read back.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared command encodings and sequencer phases.
// Assumes the usual active-low command pins ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'b0111,
        CMD_ACT   = 4'b0011,
        CMD_READ  = 4'b0101,
        CMD_WRITE = 4'b0100,
        CMD_PRE   = 4'b0010
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACT,
        PH_RCD,
        PH_RW,
        PH_PRE,
        PH_RP
    } seq_phase_e;

endpackage

// File: rtl/sdram_addr_map.sv
`timescale 1ns/1ps
// Module: sdram_addr_map
// Builds the address-pin word from the held flat address and the current
// phase. Assumes the flat address is {bank, row, column}, the bank goes on
// the top pin and the row's top pin doubles as the all-banks precharge flag.
module sdram_addr_map #(
    parameter int ROW_BITS = 11,
    parameter int COL_BITS = 8,
    localparam int ADDR_W  = 1 + ROW_BITS + COL_BITS,
    localparam int PIN_W   = ROW_BITS + 1
) (
    input  logic [ADDR_W-1:0] flat_addr,
    input  logic              is_act,
    input  logic              is_rw,
    input  logic              is_pre,
    output logic [PIN_W-1:0]  pins
);

    logic                bank;
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] col;

    // Split the flat address into its three fields.
    assign bank = flat_addr[ADDR_W-1];
    assign row  = flat_addr[ADDR_W-2 -: ROW_BITS];
    assign col  = flat_addr[COL_BITS-1:0];

    // Drive only the fields the current command uses; leave the rest at zero.
    always_comb begin
        pins = '0;
        if (is_act) begin
            pins[PIN_W-1]      = bank;
            pins[ROW_BITS-1:0] = row;
        end else if (is_rw) begin
            pins[PIN_W-1]      = bank;
            pins[COL_BITS-1:0] = col;
        end else if (is_pre) begin
            pins[ROW_BITS-1]   = 1'b1;
        end
    end

endmodule

// File: rtl/sdram_seq_ctrl.sv
`timescale 1ns/1ps
// Module: sdram_seq_ctrl
// Phase machine for one access: idle, open, row-to-column wait, column
// access, close, recovery. Holds the accepted request until the access ends.
// Assumes T_RCD >= 1 and T_RP >= 1.
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 2,
    parameter int T_RP   = 2,
    localparam int T_MAX = (T_RCD > T_RP) ? T_RCD : T_RP,
    localparam int CNT_W = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output sd_cmd_e           cmd,
    output logic              is_act,
    output logic              is_rw,
    output logic              is_pre,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata
);

    seq_phase_e       phase, phase_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             hold_we;

    // The port is free only when idle and the device is initialised.
    assign req_ready = init_done && (phase == PH_IDLE);

    // Next phase and gap counter.
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt;
        case (phase)
            PH_IDLE: if (req_valid && req_ready) phase_nx = PH_ACT;
            PH_ACT: begin
                if (T_RCD > 1) begin
                    phase_nx = PH_RCD;
                    cnt_nx   = CNT_W'(T_RCD - 1);
                end else begin
                    phase_nx = PH_RW;
                end
            end
            PH_RCD: begin
                if (cnt == CNT_W'(1)) phase_nx = PH_RW;
                else                  cnt_nx   = cnt - CNT_W'(1);
            end
            PH_RW:  phase_nx = PH_PRE;
            PH_PRE: begin
                phase_nx = PH_RP;
                cnt_nx   = CNT_W'(T_RP);
            end
            PH_RP: begin
                if (cnt == CNT_W'(1)) phase_nx = PH_IDLE;
                else                  cnt_nx   = cnt - CNT_W'(1);
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
        end
    end

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_we    <= 1'b0;
            hold_wdata <= '0;
        end else if (req_valid && req_ready) begin
            hold_addr  <= req_addr;
            hold_we    <= req_we;
            hold_wdata <= req_wdata;
        end
    end

    // Decode the command for the current phase.
    always_comb begin
        case (phase)
            PH_ACT:  cmd = CMD_ACT;
            PH_RW:   cmd = hold_we ? CMD_WRITE : CMD_READ;
            PH_PRE:  cmd = CMD_PRE;
            default: cmd = CMD_NOP;
        endcase
    end

    assign is_act = (phase == PH_ACT);
    assign is_rw  = (phase == PH_RW);
    assign is_pre = (phase == PH_PRE);

endmodule

// File: rtl/sdram_rd_pipe.sv
`timescale 1ns/1ps
// Module: sdram_rd_pipe
// Delays a read marker by the CAS latency and captures the data bus when it
// matures. It runs apart from the phase machine, so a return may overlap the
// next access. Assumes CAS_LAT >= 1.
module sdram_rd_pipe #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [CAS_LAT-1:0] pend;

    // Shift the read marker along one stage per cycle.
    generate
        if (CAS_LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) pend <= '0;
                else        pend <= rd_issue;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) pend <= '0;
                else        pend <= {pend[CAS_LAT-2:0], rd_issue};
            end
        end
    endgenerate

    // Capture the bus when the marker leaves the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pend[CAS_LAT-1];
            if (pend[CAS_LAT-1]) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sdram_seq.sv
`timescale 1ns/1ps
// Module: sdram_seq (top)
// Single-request SDRAM sequencer. Each accepted request becomes ACTIVE,
// READ or WRITE, then PRECHARGE of all banks, with counted NOP gaps. Read
// data returns CAS_LAT edges after READ. Assumes the device was initialised
// elsewhere and that init_done reports this.
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_BITS = 11,
    parameter int COL_BITS = 8,
    parameter int DATA_W   = 16,
    parameter int T_RCD    = 2,
    parameter int T_RP     = 2,
    parameter int CAS_LAT  = 3,
    localparam int ADDR_W  = 1 + ROW_BITS + COL_BITS,
    localparam int PIN_W   = ROW_BITS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [PIN_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);

    sd_cmd_e           cmd;
    logic              is_act, is_rw, is_pre;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;

    sdram_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_RP(T_RP)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cmd(cmd), .is_act(is_act), .is_rw(is_rw), .is_pre(is_pre),
        .hold_addr(hold_addr), .hold_wdata(hold_wdata)
    );

    sdram_addr_map #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
    ) u_map (
        .flat_addr(hold_addr), .is_act(is_act), .is_rw(is_rw),
        .is_pre(is_pre), .pins(sd_addr)
    );

    sdram_rd_pipe #(
        .CAS_LAT(CAS_LAT), .DATA_W(DATA_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_issue(cmd == CMD_READ),
        .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Command pins and write-data drive.
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dq_oe  = (cmd == CMD_WRITE);
    assign sd_dq_out = sd_dq_oe ? hold_wdata : '0;

endmodule

// File: rtl/sdram_seq_chk.sv
`timescale 1ns/1ps
// Module: sdram_seq_chk
// Protocol checker bound to sdram_seq. It watches only the ports, plus a
// private counter of cycles since the last ACTIVE.
module sdram_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int T_RCD    = 2,
    parameter int ROW_BITS = 11,
    localparam int PIN_W   = ROW_BITS + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_done,
    input logic             req_valid,
    input logic             req_ready,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [PIN_W-1:0] sd_addr,
    input logic             sd_dq_oe,
    input logic             rd_valid
);

    logic [3:0]  pin_cmd;
    logic        c_act, c_rw, c_pre, c_nop;
    logic [15:0] gap;
    logic        seen_act;

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign c_act   = (pin_cmd == CMD_ACT);
    assign c_rw    = (pin_cmd == CMD_READ) || (pin_cmd == CMD_WRITE);
    assign c_pre   = (pin_cmd == CMD_PRE);
    assign c_nop   = (pin_cmd == CMD_NOP);

    // Count the cycles since the last ACTIVE, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap      <= '0;
            seen_act <= 1'b0;
        end else if (c_act) begin
            gap      <= 16'd1;
            seen_act <= 1'b1;
        end else if (gap != 16'hFFFF) begin
            gap      <= gap + 16'd1;
        end
    end

    AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> c_act);                        // R2
    AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        c_rw |-> (seen_act && gap == 16'(T_RCD)));                  // R3
    AST_PRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        c_rw |=> c_pre);                                            // R4
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        c_pre |-> (sd_addr == (PIN_W'(1) << (ROW_BITS - 1))));      // R4
    AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_act || c_rw || c_pre || c_nop));                         // R5
    AST_OE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |=> !sd_dq_oe);                                    // R6
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                    // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !c_nop |-> !req_ready);                                     // R8
    AST_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !req_ready);                                 // R9

endmodule

bind sdram_seq sdram_seq_chk #(
    .T_RCD(T_RCD), .ROW_BITS(ROW_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .init_done(init_done),
    .req_valid(req_valid), .req_ready(req_ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe),
    .rd_valid(rd_valid)
);

// File: tb/sdram_seq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model plus a DRAM model, compared every cycle.
module sdram_seq_bench;

    localparam int T_RCD = 2;
    localparam int T_RP  = 2;
    localparam int CAS   = 3;
    localparam logic [3:0] E_NOP = 4'b0111, E_ACT = 4'b0011,
                           E_RD  = 4'b0101, E_WR  = 4'b0100, E_PRE = 4'b0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_done = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = 16'hBEEF;

    always #5 clk = ~clk;

    sdram_seq u_sdram_seq (
        .clk(clk), .rst_n(rst_n), .init_done(init_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0, ecount = 0;
    int k = 0;
    bit run_cmp = 1'b0, acc_seen = 1'b0;
    logic [19:0] m_addr;
    logic        m_we;
    logic [15:0] m_wdata;
    logic [15:0] shadow [logic [19:0]];
    logic [15:0] dev_mem [logic [19:0]];
    logic [10:0] open_row [2];
    bit          open_v [2];
    typedef struct { int due; logic [15:0] data; } tim_t;
    tim_t exp_q[$];
    tim_t dev_q[$];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)",
                     tag, what, act, exp, ecount);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference model: request phase counter and read-return schedule.
    always @(posedge clk) begin
        ecount++;
        if (ecount > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done (cycle %0d)", ecount);
            summary();
        end
        if (rst_n) begin
            if (k == 0) begin
                if (req_valid && init_done) begin
                    k = 1; m_addr = req_addr; m_we = req_we; m_wdata = req_wdata;
                    acc_seen = 1'b1;
                end
            end else if (k == 2 + T_RCD + T_RP) k = 0;
            else k++;
            if (k == 1 + T_RCD) begin
                if (m_we) shadow[m_addr] = m_wdata;
                else exp_q.push_back('{ecount + 1 + CAS,
                                       shadow.exists(m_addr) ? shadow[m_addr] : 16'h0});
            end
        end
    end

    // DRAM model: observes pins mid-cycle and drives read data.
    always @(negedge clk) begin
        logic [3:0] c;
        logic       b;
        logic [19:0] key;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        b = sd_addr[11];
        if (rst_n) begin
            if (c == E_ACT) begin open_row[b] = sd_addr[10:0]; open_v[b] = 1'b1; end
            if (c == E_PRE && sd_addr[10]) begin open_v[0] = 1'b0; open_v[1] = 1'b0; end
            if (c == E_RD || c == E_WR) begin
                chk("R3", "row open for column access", 32'(open_v[b]), 32'd1);
                key = {b, open_row[b], sd_addr[7:0]};
                if (c == E_WR && sd_dq_oe) dev_mem[key] = sd_dq_out;
                if (c == E_RD)
                    dev_q.push_back('{ecount + CAS,
                                      dev_mem.exists(key) ? dev_mem[key] : 16'h0});
            end
        end
        if (dev_q.size() > 0 && dev_q[0].due == ecount) begin
            sd_dq_in = dev_q[0].data;
            void'(dev_q.pop_front());
        end else sd_dq_in = 16'hBEEF;
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        logic [3:0]  e_cmd;
        logic [11:0] e_addr;
        logic        e_oe, e_rdy, e_rv;
        string       tag;
        if (run_cmp) begin
            e_cmd = E_NOP; e_addr = '0; tag = "R5";
            if (k == 1) begin
                e_cmd = E_ACT; e_addr = {m_addr[19], m_addr[18:8]}; tag = "R1/R2";
            end else if (k == 1 + T_RCD) begin
                e_cmd = m_we ? E_WR : E_RD;
                e_addr = {m_addr[19], 3'b000, m_addr[7:0]}; tag = "R1/R3";
            end else if (k == 2 + T_RCD) begin
                e_cmd = E_PRE; e_addr = 12'h400; tag = "R4";
            end
            if (!init_done) tag = "R9";
            chk(tag, "command", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(e_cmd));
            chk(tag, "address", 32'(sd_addr), 32'(e_addr));
            e_oe = (k == 1 + T_RCD) && m_we;
            chk("R6", "dq_oe", 32'(sd_dq_oe), 32'(e_oe));
            chk("R6", "dq_out", 32'(sd_dq_out), e_oe ? 32'(m_wdata) : 32'd0);
            e_rdy = (k == 0) && init_done;
            chk(init_done ? "R8" : "R9", "req_ready", 32'(req_ready), 32'(e_rdy));
            e_rv = (exp_q.size() > 0) && (exp_q[0].due == ecount);
            tag = (e_rv && e_rdy && req_valid) ? "R11" : "R7";
            chk(tag, "rd_valid", 32'(rd_valid), 32'(e_rv));
            if (e_rv) begin
                chk(tag, "rd_data", 32'(rd_data), 32'(exp_q[0].data));
                void'(exp_q.pop_front());
            end
        end
    end

    // Present a request and wait for the model to see it accepted.
    task automatic do_req(input logic we, input logic [19:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        acc_seen = 1'b0;
        while (!acc_seen) begin @(posedge clk); #1; end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", "command", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(E_NOP));
        chk("R10", "address", 32'(sd_addr), 32'd0);
        chk("R10", "dq_oe", 32'(sd_dq_oe), 32'd0);
        chk("R10", "rd_valid", 32'(rd_valid), 32'd0);
        chk("R10", "req_ready", 32'(req_ready), 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1; run_cmp = 1'b1;
        // R9: request held while init_done is low
        req_valid = 1'b1; req_we = 1'b1; req_addr = 20'h00000; req_wdata = 16'h1111;
        repeat (6) @(posedge clk);
        #1 init_done = 1'b1;
        acc_seen = 1'b0;
        while (!acc_seen) begin @(posedge clk); #1; end
        // Writes across banks, row and column extremes (R1..R6)
        do_req(1'b1, 20'hFFFFF, 16'hA5A5);
        do_req(1'b1, 20'h80123, 16'h0F0F);
        do_req(1'b1, 20'h00123, 16'hF0F0);
        do_req(1'b1, 20'h7FF00, 16'h3C3C);
        // Back-to-back reads: returns coincide with acceptance (R7, R11)
        do_req(1'b0, 20'h00000, 16'h0);
        do_req(1'b0, 20'hFFFFF, 16'h0);
        do_req(1'b0, 20'h80123, 16'h0);
        do_req(1'b0, 20'h00123, 16'h0);
        do_req(1'b0, 20'h7FF00, 16'h0);
        do_req(1'b0, 20'h12345, 16'h0);
        @(posedge clk); #1 req_valid = 1'b0;
        repeat (5) @(posedge clk);
        // Isolated write then read after idle gaps
        do_req(1'b1, 20'h80001, 16'h5A5A);
        @(posedge clk); #1 req_valid = 1'b0;
        repeat (12) @(posedge clk);
        do_req(1'b0, 20'h80001, 16'h0);
        @(posedge clk); #1 req_valid = 1'b0;
        while (k != 0 || exp_q.size() != 0) @(posedge clk);
        repeat (5) @(posedge clk);
        summary();
    end

endmodule